// File: doc/BRIEF.md
# Serial Packet Header Parser

This block sits behind a byte-wide serial receiver. It watches the incoming byte stream, skips filler, and locks onto the byte that opens each packet. It then reads a fixed four-byte header: a start marker, a destination slot, a byte that packs a sub-slot nibble and a command nibble, and a payload byte count from 0 to 255. From these it decides whether the packet is addressed to this device. The device's own slot number is a static input.

For a packet it accepts, the parser gives a single-cycle header strobe that carries the decoded fields. It then forwards each payload byte with a valid strobe and marks the final byte. For a packet it does not accept, it gives a single-cycle drop strobe and uses the length field to skip the payload, so payload contents can never be mistaken for a new packet. Start and stop strobes from the receiver force the parser back to the search state at any time. Downstream logic interprets the sub-slot and command values, for example sub-slot 0x0 for the user bus, 0xE for the boot-memory bus and 0xF for power and pin control, with commands 0 to 3 for write, read, repeated write and repeated read.

Top module: `pkt_hdr_parser`

## Requirements
- R1: While reset is high and in the first cycle after it, hdr_vld, hdr_drop, pay_vld and pay_last are all low.
- R2: While searching for a packet, every byte other than 0xF0 is ignored, including the idle value 0xFF. A 0xF0 byte starts a packet.
- R3: The byte after 0xF0 is captured as the slot. The next byte gives the sub-slot in bits [7:4] and the command in bits [3:0]. The byte after that is the payload length. All three appear on hdr_slot, hdr_sub, hdr_cmd and hdr_len together with the header or drop strobe.
- R4: A packet whose slot equals my_slot, or equals 0xFF, is accepted. hdr_vld pulses for one cycle in the cycle after the length byte is taken. hdr_bcast is high with it exactly when the slot is 0xFF.
- R5: A packet with slot 0xFE is never accepted, even when my_slot is 0xFE. hdr_drop pulses for one cycle in place of hdr_vld.
- R6: A packet for any other slot is dropped with a hdr_drop pulse. Exactly its length of payload bytes is then consumed with no pay_vld, and a 0xF0 byte among them does not start a packet.
- R7: For an accepted packet, each payload byte appears on pay_data with pay_vld high for one cycle, in the cycle after it is taken, in arrival order. Bytes arrive only when rx_vld is high, and gaps between them are allowed.
- R8: pay_last is high together with pay_vld on the final payload byte of an accepted packet, and at no other time.
- R9: A packet with length 0 gives its header or drop strobe and no payload, and the parser searches for 0xF0 starting with the next byte.
- R10: rx_start forces the parser into the search state in the cycle it is high. A byte taken in that cycle is judged as a search byte, so 0xF0 there starts a new packet.
- R11: rx_stop abandons any packet in progress in the same way. No further payload of that packet is forwarded and no pay_last is given for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| my_slot | input | 8 | This device's slot number, static |
| rx_start | input | 1 | Receiver start strobe |
| rx_stop | input | 1 | Receiver stop strobe |
| rx_vld | input | 1 | A byte is present on rx_data this cycle |
| rx_data | input | 8 | Received byte |
| hdr_vld | output | 1 | One-cycle strobe: accepted packet header |
| hdr_drop | output | 1 | One-cycle strobe: header parsed and packet dropped |
| hdr_bcast | output | 1 | Header slot was the broadcast value |
| hdr_slot | output | 8 | Captured slot |
| hdr_sub | output | 4 | Captured sub-slot |
| hdr_cmd | output | 4 | Captured command |
| hdr_len | output | 8 | Captured payload length |
| pay_vld | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte marker |

## Verification
The bench targets zero-length packets followed at once by another start marker. A parser that got this wrong would wait for a payload byte and swallow the next header. Dropped packets carry 0xF0 and a copy of a valid header inside their payload, so a design that stopped counting skipped bytes would report a phantom packet. The bench also sets my_slot to 0xFE to catch a design that matches the null slot as an ordinary address. Start and stop strobes are placed mid-header and mid-payload, and a 0xF0 is sent with the start strobe in the same cycle. These expose a parser that keeps stale counts, gives a spurious last-byte mark, or loses the marker that arrives with the strobe.

// File: rtl/pkt_hdr_parser.sv
module pkt_hdr_parser #(
  parameter logic [7:0] SOP_BYTE  = 8'hF0,
  parameter logic [7:0] BCAST_ID  = 8'hFF,
  parameter logic [7:0] NULL_ID   = 8'hFE
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] my_slot,
  input  logic       rx_start,
  input  logic       rx_stop,
  input  logic       rx_vld,
  input  logic [7:0] rx_data,
  output logic       hdr_vld,
  output logic       hdr_drop,
  output logic       hdr_bcast,
  output logic [7:0] hdr_slot,
  output logic [3:0] hdr_sub,
  output logic [3:0] hdr_cmd,
  output logic [7:0] hdr_len,
  output logic       pay_vld,
  output logic [7:0] pay_data,
  output logic       pay_last
);

  typedef enum logic [2:0] {S_HUNT, S_SLOT, S_SUBCMD, S_LEN, S_PAY, S_SKIP} st_t;

  st_t        st, cur;
  logic [7:0] slot_q, sc_q, rem;
  logic       take;

  assign cur  = (rx_start || rx_stop) ? S_HUNT : st;
  assign take = (slot_q != NULL_ID) && (slot_q == my_slot || slot_q == BCAST_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_HUNT;
      slot_q    <= '0;
      sc_q      <= '0;
      rem       <= '0;
      hdr_vld   <= 1'b0;
      hdr_drop  <= 1'b0;
      hdr_bcast <= 1'b0;
      hdr_slot  <= '0;
      hdr_sub   <= '0;
      hdr_cmd   <= '0;
      hdr_len   <= '0;
      pay_vld   <= 1'b0;
      pay_data  <= '0;
      pay_last  <= 1'b0;
    end else begin
      hdr_vld  <= 1'b0;
      hdr_drop <= 1'b0;
      pay_vld  <= 1'b0;
      pay_last <= 1'b0;
      st       <= cur;
      if (rx_vld) begin
        case (cur)
          S_HUNT:   st <= (rx_data == SOP_BYTE) ? S_SLOT : S_HUNT;
          S_SLOT: begin
            slot_q <= rx_data;
            st     <= S_SUBCMD;
          end
          S_SUBCMD: begin
            sc_q <= rx_data;
            st   <= S_LEN;
          end
          S_LEN: begin
            rem       <= rx_data;
            hdr_slot  <= slot_q;
            hdr_sub   <= sc_q[7:4];
            hdr_cmd   <= sc_q[3:0];
            hdr_len   <= rx_data;
            hdr_bcast <= (slot_q == BCAST_ID);
            hdr_vld   <= take;
            hdr_drop  <= !take;
            if (rx_data == 8'd0) st <= S_HUNT;
            else                 st <= take ? S_PAY : S_SKIP;
          end
          S_PAY: begin
            pay_vld  <= 1'b1;
            pay_data <= rx_data;
            pay_last <= (rem == 8'd1);
            rem      <= rem - 8'd1;
            st       <= (rem == 8'd1) ? S_HUNT : S_PAY;
          end
          S_SKIP: begin
            rem <= rem - 8'd1;
            st  <= (rem == 8'd1) ? S_HUNT : S_SKIP;
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/pkt_hdr_parser_chk.sv
module pkt_hdr_parser_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] my_slot,
  input logic       rx_vld,
  input logic       hdr_vld,
  input logic       hdr_drop,
  input logic       hdr_bcast,
  input logic [7:0] hdr_slot,
  input logic       pay_vld,
  input logic       pay_last
);

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({hdr_vld, hdr_drop, pay_vld}) <= 1); // R4

  AST_ACCEPT_SLOT: assert property (@(posedge clk) disable iff (rst)
    hdr_vld |-> (hdr_slot == my_slot || hdr_slot == 8'hFF)); // R4

  AST_NULL_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
    hdr_vld |-> hdr_slot != 8'hFE); // R5

  AST_BCAST_FLAG: assert property (@(posedge clk) disable iff (rst)
    hdr_vld |-> (hdr_bcast == (hdr_slot == 8'hFF))); // R4

  AST_LAST_HAS_VLD: assert property (@(posedge clk) disable iff (rst)
    pay_last |-> pay_vld); // R8

  AST_PAY_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
    pay_vld |-> $past(rx_vld)); // R7

  AST_HDR_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld || hdr_drop) |-> $past(rx_vld)); // R3

endmodule

bind pkt_hdr_parser pkt_hdr_parser_chk u_chk (
  .clk(clk), .rst(rst), .my_slot(my_slot), .rx_vld(rx_vld),
  .hdr_vld(hdr_vld), .hdr_drop(hdr_drop), .hdr_bcast(hdr_bcast),
  .hdr_slot(hdr_slot), .pay_vld(pay_vld), .pay_last(pay_last)
);

// File: tb/test_pkt_hdr_parser.sv
module test_pkt_hdr_parser;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] my_slot = 8'h12;
  logic       rx_start = 1'b0, rx_stop = 1'b0, rx_vld = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       hdr_vld, hdr_drop, hdr_bcast, pay_vld, pay_last;
  logic [7:0] hdr_slot, hdr_len, pay_data;
  logic [3:0] hdr_sub, hdr_cmd;

  int checks = 0, errors = 0;
  int hdr_n, drop_n, pay_n, last_n, last_idx;
  logic [7:0] h_slot, h_len;
  logic [3:0] h_sub, h_cmd;
  logic       h_bc;
  logic [7:0] pay_log [0:299];
  logic [7:0] exp_pay [0:299];

  always #4 clk = ~clk;

  pkt_hdr_parser i_pkt_hdr_parser (
    .clk(clk), .rst(rst), .my_slot(my_slot), .rx_start(rx_start), .rx_stop(rx_stop),
    .rx_vld(rx_vld), .rx_data(rx_data), .hdr_vld(hdr_vld), .hdr_drop(hdr_drop),
    .hdr_bcast(hdr_bcast), .hdr_slot(hdr_slot), .hdr_sub(hdr_sub), .hdr_cmd(hdr_cmd),
    .hdr_len(hdr_len), .pay_vld(pay_vld), .pay_data(pay_data), .pay_last(pay_last)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (hdr_vld) begin
        hdr_n++; h_slot = hdr_slot; h_sub = hdr_sub; h_cmd = hdr_cmd; h_len = hdr_len; h_bc = hdr_bcast;
      end
      if (hdr_drop) drop_n++;
      if (pay_vld) begin
        if (pay_n < 300) pay_log[pay_n] = pay_data;
        if (pay_last) begin last_n++; last_idx = pay_n; end
        pay_n++;
      end else if (pay_last) last_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    hdr_n = 0; drop_n = 0; pay_n = 0; last_n = 0; last_idx = -1;
  endtask

  task automatic put(input logic [7:0] b, input bit strt = 1'b0, input bit stp = 1'b0);
    rx_vld = 1'b1; rx_data = b; rx_start = strt; rx_stop = stp;
    @(negedge clk);
    rx_vld = 1'b0; rx_start = 1'b0; rx_stop = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit accepts(input logic [7:0] s, input logic [7:0] me);
    return (s != 8'hFE) && (s == me || s == 8'hFF);
  endfunction

  function automatic logic [7:0] noise();
    logic [7:0] b;
    b = 8'($urandom_range(0, 255));
    return (b == 8'hF0) ? 8'hFF : b;
  endfunction

  task automatic run_pkt(input logic [7:0] s, input logic [7:0] sc, input int len, input bit f0_in_pay, input bit gaps);
    bit acc;
    int pre;
    acc = accepts(s, my_slot);
    clear_logs();
    pre = $urandom_range(0, 4);
    for (int i = 0; i < pre; i++) begin put((i % 2) ? noise() : 8'hFF); if (gaps) gap($urandom_range(0, 2)); end
    put(8'hF0); if (gaps) gap($urandom_range(0, 2));
    put(s);     if (gaps) gap($urandom_range(0, 2));
    put(sc);    if (gaps) gap($urandom_range(0, 2));
    put(8'(len));
    for (int i = 0; i < len; i++) begin
      if (gaps) gap($urandom_range(0, 2));
      exp_pay[i] = 8'($urandom_range(0, 255));
      if (f0_in_pay && i == 0) exp_pay[i] = 8'hF0;
      if (f0_in_pay && i == 1) exp_pay[i] = my_slot;
      put(exp_pay[i]);
    end
    gap(2);
    chk(hdr_n == int'(acc), acc ? "R4" : (s == 8'hFE ? "R5" : "R6"), "header strobes", hdr_n, int'(acc));
    chk(drop_n == int'(!acc), acc ? "R4" : (s == 8'hFE ? "R5" : "R6"), "drop strobes", drop_n, int'(!acc));
    if (acc) begin
      chk(h_slot == s && h_len == 8'(len), "R3", "slot/len", {h_slot, h_len}, {s, 8'(len)});
      chk(h_sub == sc[7:4] && h_cmd == sc[3:0], "R3", "sub/cmd", {h_sub, h_cmd}, sc);
      chk(h_bc == (s == 8'hFF), "R4", "bcast flag", h_bc, int'(s == 8'hFF));
    end
    chk(pay_n == (acc ? len : 0), acc ? "R7" : "R6", "payload count", pay_n, acc ? len : 0);
    if (acc) begin
      int bad = 0;
      for (int i = 0; i < len && i < pay_n; i++) if (pay_log[i] !== exp_pay[i]) bad++;
      chk(bad == 0, "R7", "payload mismatches", bad, 0);
    end
    chk(last_n == int'(acc && len > 0), len == 0 ? "R9" : "R8", "last flags", last_n, int'(acc && len > 0));
    if (acc && len > 0) chk(last_idx == len - 1, "R8", "last position", last_idx, len - 1);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    clear_logs();
    repeat (3) @(negedge clk);
    chk(!hdr_vld && !hdr_drop && !pay_vld && !pay_last, "R1", "outputs in reset",
        {hdr_vld, hdr_drop, pay_vld, pay_last}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!hdr_vld && !hdr_drop && !pay_vld && !pay_last, "R1", "outputs after reset",
        {hdr_vld, hdr_drop, pay_vld, pay_last}, 0);

    // R2: idle and noise only
    clear_logs();
    for (int i = 0; i < 20; i++) put(i % 3 == 0 ? 8'hFF : noise());
    gap(2);
    chk(hdr_n + drop_n + pay_n == 0, "R2", "activity on non-marker bytes", hdr_n + drop_n + pay_n, 0);

    run_pkt(8'h12, 8'h01, 4, 1'b0, 1'b0);
    run_pkt(8'hFF, 8'hE3, 6, 1'b0, 1'b1);
    run_pkt(8'h34, 8'h00, 8, 1'b1, 1'b0);          // R6 marker inside skipped payload
    run_pkt(8'hFE, 8'hF0, 3, 1'b0, 1'b0);          // R5
    run_pkt(8'h12, 8'h02, 0, 1'b0, 1'b0);          // R9
    run_pkt(8'h12, 8'h13, 255, 1'b0, 1'b0);

    // R9: zero length directly followed by a marker
    clear_logs();
    put(8'hF0); put(8'h12); put(8'h01); put(8'h00);
    put(8'hF0); put(8'hFF); put(8'h02); put(8'h01); put(8'hA5);
    gap(2);
    chk(hdr_n == 2 && h_slot == 8'hFF, "R9", "headers after zero-length", hdr_n, 2);
    chk(pay_n == 1 && pay_log[0] == 8'hA5 && last_n == 1, "R9", "payload after zero-length", pay_n, 1);

    // R10: start strobe mid-header, with a marker on the same cycle
    clear_logs();
    put(8'hF0); put(8'h12);
    put(8'hF0, 1'b1);
    put(8'h12); put(8'h31); put(8'h02); put(8'h11); put(8'h22);
    gap(2);
    chk(hdr_n == 1 && h_sub == 4'h3 && h_cmd == 4'h1 && h_len == 8'd2, "R10", "header after start", hdr_n, 1);
    chk(pay_n == 2 && pay_log[1] == 8'h22 && last_idx == 1, "R10", "payload after start", pay_n, 2);

    // R11: stop strobe mid-payload
    clear_logs();
    put(8'hF0); put(8'h12); put(8'h00); put(8'h04); put(8'h01); put(8'h02);
    put(8'h03, 1'b0, 1'b1);
    put(8'h04); put(8'hF0); put(8'h12); put(8'h00); put(8'h01); put(8'h77);
    gap(2);
    chk(hdr_n == 2, "R11", "headers around stop", hdr_n, 2);
    chk(pay_n == 3 && pay_log[2] == 8'h77, "R11", "payload bytes around stop", pay_n, 3);
    chk(last_n == 1 && last_idx == 2, "R11", "last flag after stop", last_idx, 2);

    // R5: null slot refused even when it is our own
    my_slot = 8'hFE;
    run_pkt(8'hFE, 8'h00, 2, 1'b0, 1'b0);
    run_pkt(8'hFF, 8'h01, 3, 1'b0, 1'b1);
    my_slot = 8'h12;

    for (int n = 0; n < 40; n++) begin
      logic [7:0] s;
      case ($urandom_range(0, 3))
        0: s = 8'h12;
        1: s = 8'hFF;
        2: s = 8'hFE;
        default: s = noise();
      endcase
      run_pkt(s, 8'($urandom_range(0, 255)), $urandom_range(0, 20), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule